// File: doc/BRIEF.md
# Keyed Skewed Set-Index Randomizer

This block turns a cache line address into one set index per way for a skewed, randomized first-level cache. It combines the address with a secret key and passes the result through a non-linear substitution. Each way then rotates the result by its own amount, so one address can sit in a different set in every way, and the attacker cannot predict which. The indices are combinational from the line address and the current key, so a lookup gets them in the same cycle it presents the address.

The key lives in a register that can be overwritten at any time through a load strobe. The new mapping applies from the cycle after the strobe, and a busy flag is raised for exactly that cycle. The tag to be stored is widened to the whole line address, so the full block address can be rebuilt from the stored tag alone, without inverting the hash.

With the default parameters there are 26 line-address bits, 64 sets (6 index bits), 4 ways and a rotation step of 3. Under these defaults the substituted word is 8 bits wide.

Top module: `rsk_skew_index`

## Requirements
- R1: For way w, the index is computed combinationally in the same cycle, in five steps. First, m = line_addr XOR key. Second, m is XOR-folded into an 8-bit word f, where bit i of m feeds bit i mod 8 of f. Third, each nibble of f is replaced through the table 0→C, 1→5, 2→6, 3→B, 4→9, 5→0, 6→A, 7→D, 8→3, 9→E, A→F, B→8, C→4, D→7, E→1, F→2. Fourth, the result is rotated left by (w·3) mod 8, so bit i moves to bit (i+rot) mod 8. Fifth, that word is XOR-folded into 6 bits, where bit i feeds bit i mod 6.
- R2: The ways are skewed: the rotations for ways 0, 1, 2 and 3 are 0, 3, 6 and 1. As a result, some addresses land in different sets in different ways.
- R3: tag_ext always equals line_addr, whatever the key, so the block address can be rebuilt from it.
- R4: A key present on key_in while key_load is high at a rising edge becomes the mapping key from that edge on. Before the edge the old mapping stays in force, and with key_load low the key never changes.
- R5: rekey_busy is high in exactly the cycle that follows each clock edge where key_load was high, and low otherwise. Back-to-back strobes keep it high.
- R6: After reset, rekey_busy is low and the key equals the low 26 bits of KEY_SEED (default 64'h0123_4567_89AB_CDEF).
- R7: The mapping is not affine. For some fixed key and addresses a, b and c, idx(a) XOR idx(b) XOR idx(c) XOR idx(a XOR b XOR c) is non-zero.
- R8: Hold one address fixed and sweep the low 8 key bits through all 256 values. In every way, each of the 64 sets is then hit exactly 4 times.
- R9: idx_sel equals the index of the way selected by way_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_addr | input | LINE_W | Line address (bits above the line offset) |
| way_sel | input | WAY_W | Way whose index drives idx_sel |
| key_in | input | LINE_W | New key value |
| key_load | input | 1 | Rekey strobe |
| idx_all | output | WAYS*IDX_W | Per-way set indices, way w at bits [w*IDX_W +: IDX_W] |
| idx_sel | output | IDX_W | Index of the selected way |
| tag_ext | output | LINE_W | Extended tag to store |
| rekey_busy | output | 1 | High in the cycle after a rekey strobe |

## Verification
A table of address and key pairs is applied, with sparse, dense, all-ones and alternating bit patterns. These patterns show whether the fold reaches every address bit and whether every nibble goes through substitution. Comparing the four ways on the same inputs shows whether each way has its own rotation. A sweep over the low key byte catches any loss of bijectivity as a non-uniform set histogram. An affine test on XOR-related address triples separates a true substitution from a linear mix. Rekey tests sample before and after the loading edge, with single and back-to-back strobes.

// File: rtl/rsk_pkg.sv
package rsk_pkg;

   function automatic logic [3:0] sbox4(input logic [3:0] n);
      logic [3:0] r;
      case (n)
         4'h0: r = 4'hC;  4'h1: r = 4'h5;  4'h2: r = 4'h6;  4'h3: r = 4'hB;
         4'h4: r = 4'h9;  4'h5: r = 4'h0;  4'h6: r = 4'hA;  4'h7: r = 4'hD;
         4'h8: r = 4'h3;  4'h9: r = 4'hE;  4'hA: r = 4'hF;  4'hB: r = 4'h8;
         4'hC: r = 4'h4;  4'hD: r = 4'h7;  4'hE: r = 4'h1;  default: r = 4'h2;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/rsk_key_reg.sv
module rsk_key_reg #(
   parameter int unsigned    LINE_W   = 26,
   parameter logic [63:0]    KEY_SEED = 64'h0123_4567_89AB_CDEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] key_in,
   input  logic              key_load,
   output logic [LINE_W-1:0] key_q,
   output logic              busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= KEY_SEED[LINE_W-1:0];
         busy  <= 1'b0;
      end else begin
         busy <= key_load;
         if (key_load) key_q <= key_in;
      end
   end
endmodule

// File: rtl/rsk_way_hash.sv
module rsk_way_hash
   import rsk_pkg::*;
#(
   parameter int unsigned LINE_W = 26,
   parameter int unsigned IDX_W  = 6,
   parameter int unsigned FW     = 8,
   parameter int unsigned ROT    = 0
) (
   input  logic [LINE_W-1:0] line_addr,
   input  logic [LINE_W-1:0] key,
   output logic [IDX_W-1:0]  idx
);
   localparam int unsigned NCH  = (LINE_W + FW - 1) / FW;
   localparam int unsigned PADW = NCH * FW;
   localparam int unsigned NNIB = FW / 4;
   localparam int unsigned NC2  = (FW + IDX_W - 1) / IDX_W;
   localparam int unsigned PAD2 = NC2 * IDX_W;

   logic [PADW-1:0] mixed;
   logic [FW-1:0]   folded;
   logic [FW-1:0]   subst;
   logic [FW-1:0]   rotated;
   logic [PAD2-1:0] rot_pad;

   assign mixed = PADW'(line_addr ^ key);

   always_comb begin
      folded = '0;
      for (int c = 0; c < int'(NCH); c++) folded ^= mixed[c*FW +: FW];
   end

   for (genvar n = 0; n < int'(NNIB); n++) begin : g_nib
      assign subst[n*4 +: 4] = sbox4(folded[n*4 +: 4]);
   end

   if (ROT == 0) begin : g_norot
      assign rotated = subst;
   end else begin : g_rot
      assign rotated = {subst[FW-ROT-1:0], subst[FW-1:FW-ROT]};
   end

   assign rot_pad = PAD2'(rotated);

   always_comb begin
      idx = '0;
      for (int c = 0; c < int'(NC2); c++) idx ^= rot_pad[c*IDX_W +: IDX_W];
   end
endmodule

// File: rtl/rsk_skew_index.sv
module rsk_skew_index #(
   parameter int unsigned LINE_W   = 26,
   parameter int unsigned SETS     = 64,
   parameter int unsigned WAYS     = 4,
   parameter int unsigned ROT_STEP = 3,
   parameter logic [63:0] KEY_SEED = 64'h0123_4567_89AB_CDEF,
   localparam int unsigned IDX_W   = $clog2(SETS),
   localparam int unsigned WAY_W   = $clog2(WAYS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [LINE_W-1:0]     line_addr,
   input  logic [WAY_W-1:0]      way_sel,
   input  logic [LINE_W-1:0]     key_in,
   input  logic                  key_load,
   output logic [WAYS*IDX_W-1:0] idx_all,
   output logic [IDX_W-1:0]      idx_sel,
   output logic [LINE_W-1:0]     tag_ext,
   output logic                  rekey_busy
);
   localparam int unsigned FW = ((IDX_W + 3) / 4) * 4;

   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (WAYS < 2 || WAYS > 4) begin : g_bad_ways
      $error("WAYS must be between 2 and 4");
   end
   if (LINE_W < IDX_W || LINE_W > 64) begin : g_bad_line
      $error("LINE_W must cover the index and not exceed 64");
   end
   for (genvar w = 1; w < int'(WAYS); w++) begin : g_rot_chk
      if (((w * ROT_STEP) % FW) == 0) begin : g_bad_rot
         $error("ROT_STEP gives way %0d the same rotation as way 0", w);
      end
   end

   logic [LINE_W-1:0] key_q;
   logic [IDX_W-1:0]  idx_arr [WAYS];

   rsk_key_reg #(.LINE_W(LINE_W), .KEY_SEED(KEY_SEED)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_in   (key_in),
      .key_load (key_load),
      .key_q    (key_q),
      .busy     (rekey_busy)
   );

   for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
      localparam int unsigned ROT = (w * ROT_STEP) % FW;
      rsk_way_hash #(.LINE_W(LINE_W), .IDX_W(IDX_W), .FW(FW), .ROT(ROT)) u_hash (
         .line_addr (line_addr),
         .key       (key_q),
         .idx       (idx_arr[w])
      );
      assign idx_all[w*IDX_W +: IDX_W] = idx_arr[w];
   end

   always_comb begin
      idx_sel = idx_arr[0];
      for (int w = 1; w < int'(WAYS); w++) begin
         if (way_sel == WAY_W'(w)) idx_sel = idx_arr[w];
      end
   end

   assign tag_ext = line_addr;
endmodule

// File: rtl/rsk_skew_index_chk.sv
module rsk_skew_index_chk #(
   parameter int unsigned LINE_W = 26,
   parameter int unsigned IDX_W  = 6,
   parameter int unsigned WAYS   = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [LINE_W-1:0]     line_addr,
   input logic [LINE_W-1:0]     key_in,
   input logic                  key_load,
   input logic [LINE_W-1:0]     key_q,
   input logic                  rekey_busy,
   input logic [WAYS*IDX_W-1:0] idx_all
);
   p_key_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      key_load |=> key_q == $past(key_in));

   p_key_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !key_load |=> $stable(key_q));

   p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      key_load |=> rekey_busy);

   p_busy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !key_load |=> !rekey_busy);

   p_idx_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(line_addr) && $stable(key_q)) |-> $stable(idx_all));
endmodule

bind rsk_skew_index rsk_skew_index_chk #(
   .LINE_W(LINE_W), .IDX_W(IDX_W), .WAYS(WAYS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_addr  (line_addr),
   .key_in     (key_in),
   .key_load   (key_load),
   .key_q      (key_q),
   .rekey_busy (rekey_busy),
   .idx_all    (idx_all)
);

// File: tb/sim_rsk_skew_index.sv
`timescale 1ns/1ps
module sim_rsk_skew_index;
   localparam int LW = 26;
   localparam int IW = 6;
   localparam int NW = 4;
   localparam logic [63:0] SEED = 64'h0123_4567_89AB_CDEF;
   localparam logic [3:0] SB [16] = '{4'hC, 4'h5, 4'h6, 4'hB, 4'h9, 4'h0, 4'hA, 4'hD,
                                      4'h3, 4'hE, 4'hF, 4'h8, 4'h4, 4'h7, 4'h1, 4'h2};
   localparam int NV = 8;
   localparam logic [LW-1:0] V_LINE [NV] = '{26'h0000001, 26'h3FFFFFF, 26'h2AAAAAA, 26'h1555555,
                                             26'h0F0F0F0, 26'h0123456, 26'h3A5C0E7, 26'h0000000};
   localparam logic [LW-1:0] V_KEY  [NV] = '{26'h0000000, 26'h1234567, 26'h3FFFFFF, 26'h0000080,
                                             26'h2C0FFEE, 26'h00000FF, 26'h15A5A5A, 26'h3000001};
   localparam logic [1:0]    V_SEL  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LW-1:0] line_addr = '0;
   logic [1:0]    way_sel = '0;
   logic [LW-1:0] key_in = '0;
   logic          key_load = 1'b0;
   logic [NW*IW-1:0] idx_all;
   logic [IW-1:0]    idx_sel;
   logic [LW-1:0]    tag_ext;
   logic             rekey_busy;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rsk_skew_index u0 (
      .clk(clk), .rst_n(rst_n), .line_addr(line_addr), .way_sel(way_sel),
      .key_in(key_in), .key_load(key_load), .idx_all(idx_all),
      .idx_sel(idx_sel), .tag_ext(tag_ext), .rekey_busy(rekey_busy)
   );

   function automatic logic [IW-1:0] model(logic [LW-1:0] a, logic [LW-1:0] k, int w);
      logic [LW-1:0] m;
      logic [7:0] f, s, r;
      logic [IW-1:0] o;
      int rot;
      m = a ^ k;
      f = '0;
      for (int i = 0; i < LW; i++) f[i % 8] = f[i % 8] ^ m[i];
      s = {SB[f[7:4]], SB[f[3:0]]};
      rot = (w * 3) % 8;
      r = '0;
      for (int i = 0; i < 8; i++) r[(i + rot) % 8] = s[i];
      o = '0;
      for (int i = 0; i < 8; i++) o[i % IW] = o[i % IW] ^ r[i];
      return o;
   endfunction

   function automatic logic [IW-1:0] way_idx(int w);
      return idx_all[w*IW +: IW];
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load_key(logic [LW-1:0] k);
      @(negedge clk);
      key_in = k;
      key_load = 1'b1;
      @(negedge clk);
      key_load = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      finish_run();
   end

   initial begin
      logic [LW-1:0] cur_key;
      int differ;
      int found;
      logic [IW-1:0] x;
      int hist [NW][64];

      repeat (3) @(negedge clk);
      line_addr = 26'h0ABCDEF;
      #1;
      check(rekey_busy == 1'b0, "R6 busy in reset", 64'(rekey_busy), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R6: reset key is the seed
      check(way_idx(0) == model(line_addr, SEED[LW-1:0], 0), "R6 seed key",
            64'(way_idx(0)), 64'(model(line_addr, SEED[LW-1:0], 0)));
      check(rekey_busy == 1'b0, "R6 busy after reset", 64'(rekey_busy), 0);

      // Table walk: R1, R3, R9, and R2 counting
      differ = 0;
      for (int v = 0; v < NV; v++) begin
         load_key(V_KEY[v]);
         line_addr = V_LINE[v];
         way_sel = V_SEL[v];
         #1;
         for (int w = 0; w < NW; w++)
            check(way_idx(w) == model(V_LINE[v], V_KEY[v], w), "R1 way index",
                  64'(way_idx(w)), 64'(model(V_LINE[v], V_KEY[v], w)));
         check(idx_sel == model(V_LINE[v], V_KEY[v], int'(V_SEL[v])), "R9 selected way",
               64'(idx_sel), 64'(model(V_LINE[v], V_KEY[v], int'(V_SEL[v]))));
         check(tag_ext == V_LINE[v], "R3 extended tag", 64'(tag_ext), 64'(V_LINE[v]));
         if (way_idx(0) != way_idx(1) || way_idx(0) != way_idx(2) || way_idx(0) != way_idx(3))
            differ++;
      end
      check(differ > 0, "R2 skewed ways", 64'(differ), 1);

      // R9: every way select on one address
      for (int s = 0; s < NW; s++) begin
         @(negedge clk);
         way_sel = 2'(s);
         #1;
         check(idx_sel == way_idx(s), "R9 way_sel sweep", 64'(idx_sel), 64'(way_idx(s)));
      end

      // R4 / R5: rekey timing
      cur_key = 26'h1111111;
      load_key(cur_key);
      line_addr = 26'h2468ACE;
      @(negedge clk);
      key_in = 26'h3333333;
      key_load = 1'b1;
      #1;
      check(way_idx(1) == model(line_addr, cur_key, 1), "R4 old key before edge",
            64'(way_idx(1)), 64'(model(line_addr, cur_key, 1)));
      check(rekey_busy == 1'b0, "R5 busy before strobe", 64'(rekey_busy), 0);
      @(negedge clk);
      key_in = 26'h0055AA0;
      #1;
      check(way_idx(1) == model(line_addr, 26'h3333333, 1), "R4 new key after edge",
            64'(way_idx(1)), 64'(model(line_addr, 26'h3333333, 1)));
      check(rekey_busy == 1'b1, "R5 busy after strobe", 64'(rekey_busy), 1);
      @(negedge clk);
      key_load = 1'b0;
      key_in = 26'h2222222;
      #1;
      check(rekey_busy == 1'b1, "R5 back-to-back busy", 64'(rekey_busy), 1);
      check(way_idx(2) == model(line_addr, 26'h0055AA0, 2), "R4 second key",
            64'(way_idx(2)), 64'(model(line_addr, 26'h0055AA0, 2)));
      @(negedge clk);
      #1;
      check(rekey_busy == 1'b0, "R5 busy clears", 64'(rekey_busy), 0);
      check(way_idx(2) == model(line_addr, 26'h0055AA0, 2), "R4 key held without strobe",
            64'(way_idx(2)), 64'(model(line_addr, 26'h0055AA0, 2)));

      // R7: affine test on address triples, way 0
      found = 0;
      for (int c = 4; c < 64; c++) begin
         @(negedge clk); line_addr = 26'(1);     #1; x = way_idx(0);
         @(negedge clk); line_addr = 26'(2);     #1; x ^= way_idx(0);
         @(negedge clk); line_addr = 26'(c);     #1; x ^= way_idx(0);
         @(negedge clk); line_addr = 26'(3 ^ c); #1; x ^= way_idx(0);
         if (x != '0) found++;
      end
      check(found > 0, "R7 non-affine", 64'(found), 1);

      // R8: uniform sets over a key byte sweep
      for (int w = 0; w < NW; w++) for (int s = 0; s < 64; s++) hist[w][s] = 0;
      line_addr = 26'h1357BDF;
      for (int k = 0; k < 256; k++) begin
         load_key({18'h2B3C1, 8'(k)});
         #1;
         for (int w = 0; w < NW; w++) hist[w][way_idx(w)]++;
      end
      for (int w = 0; w < NW; w++) begin
         int bad_bin;
         bad_bin = -1;
         for (int s = 0; s < 64; s++) if (hist[w][s] != 4 && bad_bin < 0) bad_bin = s;
         check(bad_bin < 0, "R8 uniform sets",
               (bad_bin < 0) ? 64'd4 : 64'(hist[w][bad_bin]), 4);
      end

      finish_run();
   end
endmodule